// File: doc/BRIEF.md
# TDM Frame Sync Timing Generator

This block supplies the frame timing for a multi-slot serial audio port. It runs on the bit clock and keeps a bit position inside the current frame. From that position it derives the slot index, the bit number inside the slot, a slot-valid flag and a one-cycle frame-start strobe. The data serializers use these outputs to know which channel and bit they are moving.

In master mode the frame length comes from a programmed divider: the frame lasts (divider + 1) bit clocks, and the block drives the frame sync. The divider is set separately from slot length times slot count. Any bit clocks after the last slot are idle padding. In slave mode the block drives no sync. It realigns its position to the rising edge of an incoming sync and otherwise free-runs on the divider. Two sync shapes are offered. A short sync is one bit clock wide and can be placed late (the clock before the first data bit) or early (on the first data bit). A long sync lasts one slot length, and the early/late choice does not apply to it. A small write port holds the control word, the divider and the slot format. A combinational flag reports settings that cannot form a legal frame.

Top module: `tdm_fsync_gen`

## Requirements
- R1: Writes take effect in the cycle after the write strobe. Address 0 is the control word: bit 0 enable, bit 1 slave (1) or master (0), bit 2 long sync (1) or short sync (0), bit 3 early (1) or late (0). Address 1 holds the divider in bits [11:0]. Address 2 is the slot format: bits [1:0] give the slot length code (0 = 8, 1 = 16, 2 = 32 bit clocks) and bits [4:2] give the slot count minus one. Writes to address 3 change nothing. Reset leaves the block disabled in master short-late mode, with divider 63 and two 16-bit slots.
- R2: While disabled, every output except the configuration flag is zero and the position is held at zero. The first enabled cycle is slot 0, bit 0, with frame-start high.
- R3: In master mode frame-start pulses once every (divider + 1) bit clocks, at position 0.
- R4: At position p, while p < slot length × slot count, slot-valid is 1, the slot index is p / slot length and the bit index is p mod slot length. In the padding positions slot-valid is 0 and both indices are 0.
- R5: In master mode a short late sync is high for exactly the last position of the frame (p ≥ divider), which is the bit clock before slot 0 bit 0.
- R6: In master mode a short early sync is high only at position 0, in the same cycle as frame-start.
- R7: In master mode a long sync is high for positions 0 up to slot length − 1, whatever the early/late bit holds.
- R8: In slave mode the sync output stays low. When the incoming sync rises, a long or early-short setting makes that cycle position 0, and a late-short setting makes the next cycle position 0. Between edges the position wraps after the divider.
- R9: The configuration flag is high when divider + 1 < slot length × slot count; when long sync is used with one slot and divider + 1 ≤ slot length; when the slot count is odd and not 1; or when the slot length code is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 16 | Register write data |
| fsync_i | input | 1 | Incoming frame sync (slave mode) |
| fsync_o | output | 1 | Generated frame sync (master mode) |
| frame_start_o | output | 1 | High on slot 0 bit 0 |
| slot_valid_o | output | 1 | Current bit clock lies inside a slot |
| slot_idx_o | output | 3 | Current slot number |
| bit_idx_o | output | 5 | Bit number inside the slot |
| cfg_bad_o | output | 1 | Settings cannot form a legal frame |

## Verification
Two events can land in the same cycle. In slave mode an incoming sync edge can arrive on the very bit clock where the counter would wrap on its own. A register write can also hit a frame boundary, changing the divider or mode just as a sync would fire. Slave runs use sync periods both equal to and longer than the divider, and a random phase mixes writes with random sync pulses. In every cycle the bench checks each output against a position model built from the requirements, so any miscount or misaligned realignment shows up as a mismatch.

// File: rtl/tdm_fs_pkg.sv
package tdm_fs_pkg;

   localparam int BIT_W = 5;

   typedef struct packed {
      logic early;
      logic long_sync;
      logic slave;
      logic enable;
   } tdm_ctrl_t;

   typedef enum logic [1:0] {
      ADDR_CTRL = 2'd0,
      ADDR_DIV  = 2'd1,
      ADDR_FMT  = 2'd2,
      ADDR_NONE = 2'd3
   } tdm_addr_e;

   function automatic logic [5:0] slot_bits(input logic [1:0] code);
      case (code)
         2'd0:    slot_bits = 6'd8;
         2'd1:    slot_bits = 6'd16;
         default: slot_bits = 6'd32;
      endcase
   endfunction

   function automatic logic [2:0] slot_shift(input logic [1:0] code);
      case (code)
         2'd0:    slot_shift = 3'd3;
         2'd1:    slot_shift = 3'd4;
         default: slot_shift = 3'd5;
      endcase
   endfunction

endpackage

// File: rtl/tdm_fs_regs.sv
module tdm_fs_regs
   import tdm_fs_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int DIV_W   = 12,
   parameter int CNT_W   = 3,
   parameter int DIV_RST = 63,
   parameter int LEN_RST = 1,
   parameter int CNT_RST = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output tdm_ctrl_t         ctrl_o,
   output logic [DIV_W-1:0]  div_o,
   output logic [1:0]        len_code_o,
   output logic [CNT_W-1:0]  cnt_code_o
);

   tdm_ctrl_t        ctrl_q;
   logic [DIV_W-1:0] div_q;
   logic [1:0]       len_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
         div_q  <= DIV_W'(DIV_RST);
         len_q  <= 2'(LEN_RST);
         cnt_q  <= CNT_W'(CNT_RST);
      end else if (wr_en_i) begin
         case (tdm_addr_e'(wr_addr_i))
            ADDR_CTRL: ctrl_q <= '{early:     wr_data_i[3],
                                   long_sync: wr_data_i[2],
                                   slave:     wr_data_i[1],
                                   enable:    wr_data_i[0]};
            ADDR_DIV:  div_q  <= wr_data_i[DIV_W-1:0];
            ADDR_FMT: begin
               len_q <= wr_data_i[1:0];
               cnt_q <= wr_data_i[2 +: CNT_W];
            end
            default: ;
         endcase
      end
   end

   assign ctrl_o     = ctrl_q;
   assign div_o      = div_q;
   assign len_code_o = len_q;
   assign cnt_code_o = cnt_q;

   // R1
   reserved_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == ADDR_NONE) |=>
         ($stable(ctrl_q) && $stable(div_q) && $stable(len_q) && $stable(cnt_q)));

endmodule

// File: rtl/tdm_fs_counter.sv
module tdm_fs_counter #(
   parameter int DIV_W    = 12,
   parameter int SLAVE_EN = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             slave_i,
   input  logic             late_short_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             fsync_i,
   output logic [DIV_W-1:0] pos_o
);

   logic [DIV_W-1:0] pos_q, pos_cur, pos_nxt;
   logic             rise, realign_now, realign_next;

   generate
      if (SLAVE_EN != 0) begin : g_slave
         logic fs_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) fs_q <= 1'b0;
            else         fs_q <= fsync_i;
         end
         assign rise = slave_i && fsync_i && !fs_q;
      end else begin : g_master_only
         logic unused_in;
         assign unused_in = fsync_i ^ slave_i;
         assign rise      = 1'b0;
      end
   endgenerate

   assign realign_now  = rise && !late_short_i;
   assign realign_next = rise && late_short_i;
   assign pos_cur      = realign_now ? '0 : pos_q;

   always_comb begin
      if (!en_i)                  pos_nxt = '0;
      else if (realign_next)      pos_nxt = '0;
      else if (pos_cur >= div_i)  pos_nxt = '0;
      else                        pos_nxt = pos_cur + DIV_W'(1);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pos_q <= '0;
      else         pos_q <= pos_nxt;
   end

   assign pos_o = pos_cur;

   // R2
   hold_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (pos_q == '0));

   // R8
   late_realign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && realign_next) |=> (pos_q == '0));

endmodule

// File: rtl/tdm_fs_decode.sv
module tdm_fs_decode
   import tdm_fs_pkg::*;
#(
   parameter int DIV_W = 12,
   parameter int CNT_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             slave_i,
   input  logic             long_i,
   input  logic             early_i,
   input  logic [DIV_W-1:0] pos_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic [1:0]       len_code_i,
   input  logic [CNT_W-1:0] cnt_code_i,
   output logic             fsync_o,
   output logic             frame_start_o,
   output logic             slot_valid_o,
   output logic [CNT_W-1:0] slot_idx_o,
   output logic [BIT_W-1:0] bit_idx_o,
   output logic             cfg_bad_o
);

   localparam int SPAN_W = 6 + CNT_W + 1;
   localparam int CMP_W  = (DIV_W + 1 > SPAN_W) ? DIV_W + 1 : SPAN_W;

   logic [5:0]        slen;
   logic [CNT_W:0]    nslot;
   logic [SPAN_W-1:0] span;
   logic [DIV_W:0]    flen;
   logic [DIV_W-1:0]  shifted;
   logic              in_span, fs_raw;

   assign slen    = slot_bits(len_code_i);
   assign nslot   = {1'b0, cnt_code_i} + (CNT_W+1)'(1);
   assign span    = SPAN_W'(slen) * SPAN_W'(nslot);
   assign flen    = {1'b0, div_i} + (DIV_W+1)'(1);
   assign shifted = pos_i >> slot_shift(len_code_i);
   assign in_span = CMP_W'(pos_i) < CMP_W'(span);

   always_comb begin
      if (long_i)       fs_raw = CMP_W'(pos_i) < CMP_W'(slen);
      else if (early_i) fs_raw = (pos_i == '0);
      else              fs_raw = (pos_i >= div_i);
   end

   assign fsync_o       = en_i && !slave_i && fs_raw;
   assign frame_start_o = en_i && (pos_i == '0);
   assign slot_valid_o  = en_i && in_span;
   assign slot_idx_o    = slot_valid_o ? shifted[CNT_W-1:0] : '0;
   assign bit_idx_o     = slot_valid_o ? (pos_i[BIT_W-1:0] & BIT_W'(slen - 6'd1)) : '0;

   assign cfg_bad_o = (CMP_W'(flen) < CMP_W'(span))
                   || (long_i && nslot == (CNT_W+1)'(1) && CMP_W'(flen) <= CMP_W'(slen))
                   || (nslot != (CNT_W+1)'(1) && nslot[0])
                   || (len_code_i == 2'd3);

   // R4
   start_in_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_start_o |-> slot_valid_o);

   // R4
   slot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_valid_o |-> ({1'b0, slot_idx_o} < nslot));

endmodule

// File: rtl/tdm_fsync_gen.sv
module tdm_fsync_gen
   import tdm_fs_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int DIV_W     = 12,
   parameter int MAX_SLOTS = 8,
   parameter int DIV_RST   = 63,
   parameter int SLAVE_EN  = 1
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          wr_en_i,
   input  logic [1:0]                    wr_addr_i,
   input  logic [DATA_W-1:0]             wr_data_i,
   input  logic                          fsync_i,
   output logic                          fsync_o,
   output logic                          frame_start_o,
   output logic                          slot_valid_o,
   output logic [$clog2(MAX_SLOTS)-1:0]  slot_idx_o,
   output logic [BIT_W-1:0]              bit_idx_o,
   output logic                          cfg_bad_o
);

   localparam int CNT_W = $clog2(MAX_SLOTS);

   generate
      if (DIV_W < 9 || DIV_W > DATA_W) begin : g_bad_div_w
         $error("DIV_W must lie between 9 and DATA_W");
      end
      if (MAX_SLOTS < 2 || MAX_SLOTS > 16 || (MAX_SLOTS & (MAX_SLOTS - 1)) != 0) begin : g_bad_slots
         $error("MAX_SLOTS must be a power of two from 2 to 16");
      end
      if (DATA_W < 2 + CNT_W) begin : g_bad_data_w
         $error("DATA_W too narrow for the slot format field");
      end
   endgenerate

   tdm_ctrl_t        ctrl;
   logic [DIV_W-1:0] div, pos;
   logic [1:0]       len_code;
   logic [CNT_W-1:0] cnt_code;
   logic             late_short;

   tdm_fs_regs #(
      .DATA_W (DATA_W),
      .DIV_W  (DIV_W),
      .CNT_W  (CNT_W),
      .DIV_RST(DIV_RST)
   ) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .ctrl_o     (ctrl),
      .div_o      (div),
      .len_code_o (len_code),
      .cnt_code_o (cnt_code)
   );

   assign late_short = !ctrl.long_sync && !ctrl.early;

   tdm_fs_counter #(
      .DIV_W   (DIV_W),
      .SLAVE_EN(SLAVE_EN)
   ) u_counter (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .en_i         (ctrl.enable),
      .slave_i      (ctrl.slave),
      .late_short_i (late_short),
      .div_i        (div),
      .fsync_i      (fsync_i),
      .pos_o        (pos)
   );

   tdm_fs_decode #(
      .DIV_W(DIV_W),
      .CNT_W(CNT_W)
   ) u_decode (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .en_i          (ctrl.enable),
      .slave_i       (ctrl.slave),
      .long_i        (ctrl.long_sync),
      .early_i       (ctrl.early),
      .pos_i         (pos),
      .div_i         (div),
      .len_code_i    (len_code),
      .cnt_code_i    (cnt_code),
      .fsync_o       (fsync_o),
      .frame_start_o (frame_start_o),
      .slot_valid_o  (slot_valid_o),
      .slot_idx_o    (slot_idx_o),
      .bit_idx_o     (bit_idx_o),
      .cfg_bad_o     (cfg_bad_o)
   );

   logic master_late;
   assign master_late = ctrl.enable && !ctrl.slave && late_short;

   // R8
   slave_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl.slave |-> !fsync_o);

   // R5
   short_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fsync_o && !ctrl.long_sync && div != '0 && !wr_en_i) |=> !fsync_o);

   // R5
   late_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_start_o && master_late && $past(master_late) && $past(!wr_en_i))
         |-> $past(fsync_o));

   // R6
   early_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fsync_o && !ctrl.long_sync && ctrl.early) |-> frame_start_o);

   // R7
   long_first_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fsync_o && ctrl.long_sync) |-> (slot_valid_o && slot_idx_o == '0));

endmodule

// File: tb/tb_tdm_fsync_gen.sv
module tb_tdm_fsync_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        fs_in = 1'b0;
   logic        fsync_o, frame_start_o, slot_valid_o, cfg_bad_o;
   logic [2:0]  slot_idx_o;
   logic [4:0]  bit_idx_o;

   always #2 clk = ~clk;

   tdm_fsync_gen dut (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .wr_en_i       (wr_en),
      .wr_addr_i     (wr_addr),
      .wr_data_i     (wr_data),
      .fsync_i       (fs_in),
      .fsync_o       (fsync_o),
      .frame_start_o (frame_start_o),
      .slot_valid_o  (slot_valid_o),
      .slot_idx_o    (slot_idx_o),
      .bit_idx_o     (bit_idx_o),
      .cfg_bad_o     (cfg_bad_o)
   );

   bit    m_en, m_slave, m_long, m_early, prev_fs, done;
   int    m_div = 63, m_code = 1, m_cnt = 1, mp = 0;
   int    total = 0, bad = 0;
   string phase = "R3";

   task automatic chk(string req, int act, int exp, string what);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int slot_len(int code);
      return (code == 0) ? 8 : (code == 1) ? 16 : 32;
   endfunction

   function automatic int cfg_expect(int div, int code, int cnt, bit lng);
      int slen = slot_len(code);
      int ns = cnt + 1;
      int flen = div + 1;
      return ((flen < slen * ns) || (lng && ns == 1 && flen <= slen) ||
              (ns != 1 && (ns % 2) == 1) || code == 3) ? 1 : 0;
   endfunction

   task automatic step(bit we, int a, int d, bit fs);
      int pc, slen, span, e_fst, e_v, e_si, e_bi, e_fso;
      bit rise;
      string t, ts, tf;
      wr_en = we; wr_addr = 2'(a); wr_data = 16'(d); fs_in = fs;
      #1;
      rise = m_slave && fs && !prev_fs;
      pc = (rise && (m_long || m_early)) ? 0 : mp;
      slen = slot_len(m_code);
      span = slen * (m_cnt + 1);
      e_fst = 0; e_v = 0; e_si = 0; e_bi = 0; e_fso = 0;
      if (m_en) begin
         e_fst = (pc == 0);
         e_v = (pc < span);
         e_si = e_v ? pc / slen : 0;
         e_bi = e_v ? pc % slen : 0;
         if (!m_slave)
            e_fso = m_long ? (pc < slen) : m_early ? (pc == 0) : (pc >= m_div);
      end
      t  = !m_en ? "R2" : m_slave ? "R8" : phase;
      ts = !m_en ? "R2" : m_slave ? "R8" : "R4";
      tf = !m_en ? "R2" : m_slave ? "R8" : m_long ? "R7" : m_early ? "R6" : "R5";
      chk(t,  int'(frame_start_o), e_fst, "frame_start");
      chk(ts, int'(slot_valid_o), e_v, "slot_valid");
      chk(ts, int'(slot_idx_o), e_si, "slot_idx");
      chk(ts, int'(bit_idx_o), e_bi, "bit_idx");
      chk(tf, int'(fsync_o), e_fso, "fsync_o");
      chk("R9", int'(cfg_bad_o), cfg_expect(m_div, m_code, m_cnt, m_long), "cfg_bad");
      @(posedge clk);
      if (!m_en) mp = 0;
      else if (rise && !m_long && !m_early) mp = 0;
      else mp = (pc >= m_div) ? 0 : pc + 1;
      prev_fs = fs;
      if (we) begin
         case (a)
            0: begin
               m_en = d[0]; m_slave = d[1]; m_long = d[2]; m_early = d[3];
            end
            1: m_div = d & 32'hfff;
            2: begin
               m_code = d & 3; m_cnt = (d >> 2) & 7;
            end
            default: ;
         endcase
      end
      @(negedge clk);
   endtask

   task automatic wr(int a, int d);
      step(1'b1, a, d, 1'b0);
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) step(1'b0, 0, 0, 1'b0);
   endtask

   task automatic slave_run(int n, int period, int width, int offset);
      for (int k = 0; k < n; k++) step(1'b0, 0, 0, ((k + offset) % period) < width);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state: disabled, legal default format
      chk("R1", int'(cfg_bad_o), 0, "reset cfg_bad");
      chk("R1", int'(fsync_o), 0, "reset fsync_o");
      chk("R1", int'(frame_start_o), 0, "reset frame_start");
      @(negedge clk);
      idle(4);
      // R3 master short late with reset divider and format
      phase = "R3";
      wr(0, 1);
      idle(140);
      // R4 padding after two 8-bit slots, then wide and six-slot frames
      phase = "R4";
      wr(1, 19); wr(2, 0 | (1 << 2)); idle(60);
      wr(1, 255); wr(2, 2 | (7 << 2)); idle(300);
      wr(1, 47); wr(2, 0 | (5 << 2)); idle(100);
      // R6 early short sync
      phase = "R6";
      wr(0, 1 | 8); idle(100);
      // R7 long sync, early bit set then clear
      phase = "R7";
      wr(2, 2); wr(1, 39); wr(0, 1 | 4 | 8); idle(90);
      wr(0, 1 | 4); idle(90);
      // R1 reserved address leaves everything unchanged
      phase = "R1";
      wr(3, 16'hffff); idle(50);
      // R2 disable mid-frame and re-enable
      phase = "R2";
      wr(0, 0); idle(10); wr(0, 1); idle(30);
      // R8 slave modes
      phase = "R8";
      wr(1, 31); wr(2, 1 | (1 << 2));
      wr(0, 1 | 2);     slave_run(200, 32, 1, 5);
      wr(0, 1 | 2 | 8); slave_run(200, 32, 1, 3);
      wr(0, 1 | 2 | 4); slave_run(200, 32, 16, 7);
      wr(0, 1 | 2);     slave_run(200, 37, 1, 0);
      idle(80);
      // R9 configuration legality corners
      phase = "R3";
      wr(0, 1); wr(1, 30); idle(3);
      wr(1, 31); idle(3);
      wr(2, 1); wr(0, 1 | 4); wr(1, 15); idle(3);
      wr(1, 16); idle(3);
      wr(2, 1 | (2 << 2)); idle(3);
      wr(2, 3 | (1 << 2)); idle(3);
      wr(2, 1 | (1 << 2)); wr(1, 63); wr(0, 1);
      // random mix of writes, modes and incoming syncs
      for (int k = 0; k < 3000; k++) begin
         int a, d;
         bit we;
         we = ($urandom % 20) == 0;
         a = $urandom % 4;
         case (a)
            0: d = $urandom % 16;
            1: d = 8 + ($urandom % 120);
            default: d = $urandom % 65536;
         endcase
         step(we, a, d, ($urandom % 6) == 0);
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule